// File: doc/BRIEF.md
# Remote Terminal Configuration Control

This block holds the configuration state of a remote terminal on a MIL-STD-1553 style command/response bus. It owns the terminal address, the busy bit and three run-time options. It also chooses, at the start of every received message, which data-table pointer the message uses. A host writes two registers through a simple write port. Register select 0 is the basic status register and select 1 is the option register. The message decoder upstream reports each message with a start strobe, the commanded terminal address and the subaddress, and marks the message end with an end strobe.

The terminal address comes from hard-wired pins at reset, and software may overwrite it unless the address-lock option is set. In standard mode the busy bit behaves as the protocol requires: a software reset or a reset mode code (mode code 8) raises it. In plain mode it is ordinary storage. Broadcast traffic, meaning commanded address 31, shares the 30 receive pointers by default and carries a tag bit that marks it as broadcast. With the split option set, broadcast traffic uses a second bank of 30 pointers.

Top module: `rt_cfg_ctrl`

## Requirements
- R1: After reset the address output equals the hard-wired pins, and busy and pointer-valid are 0. All options are 0.
- R2: A write with select 0 loads data bits 15:11 into the terminal address when option bit 0 (address lock) is clear.
- R3: When option bit 0 is set, a select-0 write leaves the terminal address unchanged.
- R4: Every select-0 write loads data bit 3 into the busy bit, in both busy modes.
- R5: With option bit 1 clear (standard busy), a software reset or mode code 8 reset pulse sets busy on the next cycle, even if a select-0 write in the same cycle clears bit 3.
- R6: With option bit 1 set (plain busy), software reset and mode code 8 reset pulses leave busy unchanged.
- R7: With option bit 2 clear (shared tables), a valid message to subaddress s gets pointer index s-1. The broadcast tag is 1 exactly when the commanded address is 31.
- R8: With option bit 2 set (split tables), a broadcast message to subaddress s gets index 29+s. A non-broadcast message keeps index s-1.
- R9: Pointer-valid stays 0 for subaddress 0 or 31 (mode codes), and for a commanded address that is neither the terminal address nor 31.
- R10: A select-1 write loads data bits 2:0 into the options only while no message is active. Options are sampled at each message start.
- R11: Pointer outputs update one cycle after the start strobe. The end strobe clears pointer-valid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 1 | 0 = basic status, 1 = options |
| wr_data_i | input | 16 | Host write data |
| hw_addr_i | input | 5 | Hard-wired terminal address |
| soft_rst_i | input | 1 | Software reset pulse |
| mc8_rst_i | input | 1 | Reset mode code pulse |
| msg_start_i | input | 1 | Message start strobe |
| msg_end_i | input | 1 | Message end strobe |
| msg_taddr_i | input | 5 | Commanded terminal address |
| msg_sa_i | input | 5 | Commanded subaddress |
| rt_addr_o | output | 5 | Current terminal address |
| busy_o | output | 1 | Busy bit |
| ptr_valid_o | output | 1 | Pointer index valid |
| ptr_idx_o | output | 6 | Selected data-table pointer index |
| bcst_tag_o | output | 1 | Broadcast tag for the message |

## Verification
The assertions check the following on every cycle: address loading and address lock on status writes, the busy response to resets in both modes, the option freeze while a message is active, and that mode-code subaddresses never produce a valid pointer. Only the bench scenarios show the exact pointer index arithmetic for shared and split tables, the hard-wired address load at reset, and the end-to-end effect of a rejected option write on a later message.

// File: rtl/rt_cfg_pkg.sv
package rt_cfg_pkg;
  parameter int unsigned ADDR_W  = 5;
  parameter int unsigned DATA_W  = 16;
  parameter int unsigned NUM_SA  = 30;
  localparam int unsigned IDX_W  = $clog2(2 * NUM_SA);
  localparam logic [ADDR_W-1:0] BCST_ADDR = '1;
  localparam int unsigned ADDR_LSB = DATA_W - ADDR_W;
  localparam int unsigned BUSY_BIT = 3;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_OPTION = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic split_tbl;
    logic busy_plain;
    logic addr_lock;
  } opt_t;
endpackage

// File: rtl/rt_addr_reg.sv
module rt_addr_reg
  import rt_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic              wr_stat_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              lock_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  addr_q <= hw_addr_i;
    else if (wr_stat_i && !lock_i) addr_q <= wr_addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rt_busy_ctl.sv
module rt_busy_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stat_i,
  input  logic wr_busy_i,
  input  logic rst_req_i,
  input  logic plain_i,
  output logic busy_o
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (wr_stat_i)             busy_d = wr_busy_i;
    // protocol reset overrides a host write in the same cycle
    if (rst_req_i && !plain_i) busy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rt_ptr_sel.sv
module rt_ptr_sel
  import rt_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              end_i,
  input  logic [ADDR_W-1:0] taddr_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              split_i,
  output logic              active_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              tag_o
);
  localparam logic [ADDR_W-1:0] SA_MODE_HI = '1;
  localparam logic [IDX_W-1:0]  BANK_OFS   = IDX_W'(NUM_SA);

  logic             is_bcst, is_mode, hit;
  logic [IDX_W-1:0] base_idx, idx_d;
  logic             active_q, valid_q, tag_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    is_bcst  = (taddr_i == BCST_ADDR);
    is_mode  = (sa_i == '0) || (sa_i == SA_MODE_HI);
    hit      = !is_mode && (is_bcst || taddr_i == own_addr_i);
    base_idx = IDX_W'(sa_i) - IDX_W'(1);
    idx_d    = (split_i && is_bcst) ? base_idx + BANK_OFS : base_idx;
    if (!hit) idx_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      idx_q    <= '0;
      tag_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      valid_q  <= hit;
      idx_q    <= idx_d;
      tag_q    <= is_bcst;
    end else if (end_i) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign valid_o  = valid_q;
  assign idx_o    = idx_q;
  assign tag_o    = tag_q;
endmodule

// File: rtl/rt_cfg_ctrl.sv
module rt_cfg_ctrl
  import rt_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic              soft_rst_i,
  input  logic              mc8_rst_i,
  input  logic              msg_start_i,
  input  logic              msg_end_i,
  input  logic [ADDR_W-1:0] msg_taddr_i,
  input  logic [ADDR_W-1:0] msg_sa_i,
  output logic [ADDR_W-1:0] rt_addr_o,
  output logic              busy_o,
  output logic              ptr_valid_o,
  output logic [IDX_W-1:0]  ptr_idx_o,
  output logic              bcst_tag_o
);
  opt_t opt_q;
  logic wr_stat, wr_opt, msg_active;
  logic unused_wr_bits;

  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign wr_opt  = wr_en_i && (wr_sel_i == SEL_OPTION);
  assign unused_wr_bits = ^wr_data_i[ADDR_LSB-1:BUSY_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   opt_q <= '0;
    else if (wr_opt && !msg_active) opt_q <= opt_t'(wr_data_i[$bits(opt_t)-1:0]);
  end

  rt_addr_reg i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_addr_i (hw_addr_i),
    .wr_stat_i (wr_stat),
    .wr_addr_i (wr_data_i[DATA_W-1:ADDR_LSB]),
    .lock_i    (opt_q.addr_lock),
    .addr_o    (rt_addr_o)
  );

  rt_busy_ctl i_busy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stat_i (wr_stat),
    .wr_busy_i (wr_data_i[BUSY_BIT]),
    .rst_req_i (soft_rst_i || mc8_rst_i),
    .plain_i   (opt_q.busy_plain),
    .busy_o    (busy_o)
  );

  rt_ptr_sel i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (msg_start_i),
    .end_i      (msg_end_i),
    .taddr_i    (msg_taddr_i),
    .sa_i       (msg_sa_i),
    .own_addr_i (rt_addr_o),
    .split_i    (opt_q.split_tbl),
    .active_o   (msg_active),
    .valid_o    (ptr_valid_o),
    .idx_o      (ptr_idx_o),
    .tag_o      (bcst_tag_o)
  );
endmodule

// File: rtl/rt_cfg_chk.sv
module rt_cfg_chk
  import rt_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              soft_rst_i,
  input logic              mc8_rst_i,
  input logic              msg_start_i,
  input logic [ADDR_W-1:0] msg_sa_i,
  input logic [ADDR_W-1:0] rt_addr_o,
  input logic              busy_o,
  input logic              ptr_valid_o,
  input logic [IDX_W-1:0]  ptr_idx_o,
  input logic              bcst_tag_o,
  input opt_t              opt_q,
  input logic              msg_active
);
  a_r2_soft_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_sel_i && !opt_q.addr_lock |=> rt_addr_o == $past(wr_data_i[DATA_W-1:ADDR_LSB]));

  a_r3_addr_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_q.addr_lock |=> $stable(rt_addr_o));

  a_r5_std_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i || mc8_rst_i) && !opt_q.busy_plain |=> busy_o);

  a_r6_plain_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i || mc8_rst_i) && opt_q.busy_plain && !(wr_en_i && !wr_sel_i) |=> $stable(busy_o));

  a_r9_mode_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_start_i && (msg_sa_i == '0 || msg_sa_i == '1) |=> !ptr_valid_o);

  a_r7_shared_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o && !bcst_tag_o |-> ptr_idx_o < IDX_W'(NUM_SA));

  a_r10_opt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_active && wr_en_i && wr_sel_i |=> opt_q == $past(opt_q));
endmodule

bind rt_cfg_ctrl rt_cfg_chk i_rt_cfg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .soft_rst_i  (soft_rst_i),
  .mc8_rst_i   (mc8_rst_i),
  .msg_start_i (msg_start_i),
  .msg_sa_i    (msg_sa_i),
  .rt_addr_o   (rt_addr_o),
  .busy_o      (busy_o),
  .ptr_valid_o (ptr_valid_o),
  .ptr_idx_o   (ptr_idx_o),
  .bcst_tag_o  (bcst_tag_o),
  .opt_q       (opt_q),
  .msg_active  (msg_active)
);

// File: tb/test_rt_cfg_ctrl.sv
module test_rt_cfg_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [4:0]  hw_addr = 5'd9;
  logic        soft_rst = 1'b0, mc8_rst = 1'b0;
  logic        msg_start = 1'b0, msg_end = 1'b0;
  logic [4:0]  msg_taddr = '0, msg_sa = '0;
  logic [4:0]  rt_addr;
  logic        busy, ptr_valid, bcst_tag;
  logic [5:0]  ptr_idx;
  int          n_chk = 0, n_err = 0, cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rt_cfg_ctrl i_rt_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .hw_addr_i(hw_addr), .soft_rst_i(soft_rst),
    .mc8_rst_i(mc8_rst), .msg_start_i(msg_start), .msg_end_i(msg_end),
    .msg_taddr_i(msg_taddr), .msg_sa_i(msg_sa), .rt_addr_o(rt_addr),
    .busy_o(busy), .ptr_valid_o(ptr_valid), .ptr_idx_o(ptr_idx),
    .bcst_tag_o(bcst_tag)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [15:0] stat_word(logic [4:0] a, bit b);
    return {a, 7'd0, b, 3'd0};
  endfunction

  task automatic pulse_rst(bit sw, bit mc);
    @(negedge clk); soft_rst = sw; mc8_rst = mc;
    @(negedge clk); soft_rst = 1'b0; mc8_rst = 1'b0;
  endtask

  task automatic start_msg(logic [4:0] ta, logic [4:0] sa);
    @(negedge clk); msg_start = 1'b1; msg_taddr = ta; msg_sa = sa;
    @(negedge clk); msg_start = 1'b0;
  endtask

  task automatic end_msg();
    @(negedge clk); msg_end = 1'b1;
    @(negedge clk); msg_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 addr", rt_addr, 9);
    chk("R1 busy", busy, 0);
    chk("R1 valid", ptr_valid, 0);
  endtask

  task automatic t_soft_addr();
    wr(1'b0, stat_word(5'd17, 1'b1));
    chk("R2 addr", rt_addr, 17);
    chk("R4 busy set", busy, 1);
    wr(1'b0, stat_word(5'd17, 1'b0));
    chk("R4 busy clr", busy, 0);
  endtask

  task automatic t_lock();
    wr(1'b1, 16'h0001);
    wr(1'b0, stat_word(5'd3, 1'b0));
    chk("R3 addr locked", rt_addr, 17);
    wr(1'b1, 16'h0000);
    chk("R3 unlock keeps", rt_addr, 17);
  endtask

  task automatic t_busy_std();
    pulse_rst(1'b1, 1'b0);
    chk("R5 soft rst", busy, 1);
    wr(1'b0, stat_word(5'd17, 1'b0));
    chk("R5 host clr", busy, 0);
    pulse_rst(1'b0, 1'b1);
    chk("R5 mc8", busy, 1);
    wr(1'b0, stat_word(5'd17, 1'b0));
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = stat_word(5'd17, 1'b0); soft_rst = 1'b1;
    @(negedge clk); wr_en = 1'b0; soft_rst = 1'b0;
    chk("R5 rst beats write", busy, 1);
    wr(1'b0, stat_word(5'd17, 1'b0));
  endtask

  task automatic t_busy_plain();
    wr(1'b1, 16'h0002);
    pulse_rst(1'b1, 1'b0);
    chk("R6 soft rst", busy, 0);
    wr(1'b0, stat_word(5'd17, 1'b1));
    pulse_rst(1'b0, 1'b1);
    chk("R6 mc8 holds", busy, 1);
    wr(1'b0, stat_word(5'd17, 1'b0));
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_shared();
    start_msg(5'd17, 5'd5);
    chk("R7 valid", ptr_valid, 1);
    chk("R7 idx", ptr_idx, 4);
    chk("R7 tag rx", bcst_tag, 0);
    end_msg();
    chk("R11 end clears", ptr_valid, 0);
    start_msg(5'd31, 5'd5);
    chk("R7 bcst idx", ptr_idx, 4);
    chk("R7 bcst tag", bcst_tag, 1);
    end_msg();
  endtask

  task automatic t_split();
    wr(1'b1, 16'h0004);
    start_msg(5'd31, 5'd1);
    chk("R8 sa1 idx", ptr_idx, 30);
    chk("R8 tag", bcst_tag, 1);
    end_msg();
    start_msg(5'd31, 5'd30);
    chk("R8 sa30 idx", ptr_idx, 59);
    end_msg();
    start_msg(5'd17, 5'd30);
    chk("R8 rx idx", ptr_idx, 29);
    chk("R8 rx tag", bcst_tag, 0);
    end_msg();
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_nohit();
    start_msg(5'd17, 5'd0);
    chk("R9 sa0", ptr_valid, 0);
    end_msg();
    start_msg(5'd31, 5'd31);
    chk("R9 sa31", ptr_valid, 0);
    end_msg();
    start_msg(5'd4, 5'd2);
    chk("R9 other addr", ptr_valid, 0);
    end_msg();
  endtask

  task automatic t_opt_freeze();
    start_msg(5'd17, 5'd2);
    wr(1'b1, 16'h0004);
    end_msg();
    start_msg(5'd31, 5'd2);
    chk("R10 write ignored", ptr_idx, 1);
    end_msg();
    wr(1'b1, 16'h0004);
    start_msg(5'd31, 5'd2);
    chk("R10 idle write", ptr_idx, 31);
    end_msg();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_soft_addr();
    t_lock();
    t_busy_std();
    t_busy_plain();
    t_shared();
    t_split();
    t_nohit();
    t_opt_freeze();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule